// File: doc/BRIEF.md
# Reset Cause Register and Reset Pulse Generator

This block is the reset-source register of a small microcontroller reset controller. It takes the individual reset requests: supply monitor, external pin, watchdog timeout, missing-clock timeout, comparator trip, flash error and a software force. When one of them is accepted, it produces a fixed-length system reset pulse. It also records which source caused that reset as a one-hot cause flag, and the flag stays unchanged until the next reset. The detectors themselves are outside the block and appear only as request inputs.

Software reaches the register through a simple register bus at address 0xEF. Read and write have different meanings for several bits. A read returns the cause flags. A write to the same bits enables or disables the optional reset sources (supply monitor, missing-clock detector, comparator), or forces a software reset. The synchronous power-on input `rst_i` clears the block to its power-on state and also produces a reset pulse.

Top module: `rstcause_ctrl`

## Requirements
- R1: While `rst_i` is high and for PULSE_CYCLES cycles after it falls, `sys_rst_o` is 1. After power-on the register reads 0x82 (only the supply/power flag, bit 1, plus bit 7), `vmon_en_o`=1, `mcd_en_o`=0 and `cmp_en_o`=0.
- R2: Bit 7 of every register read is 1, whatever value was written to bit 7.
- R3: An accepted request in cycle t drives `sys_rst_o` high from cycle t+1 for exactly PULSE_CYCLES cycles (16 by default), with no retrigger.
- R4: A pin, watchdog or flash-error request sets only its own flag, reading 0x81 (bit 0), 0x88 (bit 3) or 0xC0 (bit 6).
- R5: A write with bit 4 = 1 forces a reset, and the register then reads 0x90. A write with bit 4 = 0 causes no reset.
- R6: Write bit 2 sets the missing-clock enable. A missing-clock request resets only while that enable is 1, and the register then reads 0x84.
- R7: Write bit 5 sets the comparator enable. A low level on `cmp_trip_n_i` resets only while that enable is 1, and the register then reads 0xA0.
- R8: Write bit 1 sets the supply-monitor enable. A supply-monitor request resets only while that enable is 1. It then reads 0x82 and returns all three enables to their power-on values.
- R9: When several requests are accepted in the same cycle, one flag is recorded by this priority: supply monitor, pin, watchdog, missing clock, comparator, flash error, software.
- R10: The enable outputs keep their values through pin, watchdog, missing-clock, comparator, flash and software resets.
- R11: While `sys_rst_o` is high, new requests and register writes are ignored, and the cause flags do not change.
- R12: A read strobe at address 0xEF returns the register on `bus_rdata_o` in the next cycle. In every other cycle `bus_rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| vmon_req_i | input | 1 | Supply-monitor reset request |
| pin_req_i | input | 1 | External reset-pin request (synchronised) |
| wdt_req_i | input | 1 | Watchdog timeout request |
| mcd_req_i | input | 1 | Missing-clock timeout request |
| cmp_trip_n_i | input | 1 | Comparator output, low requests reset |
| flash_err_i | input | 1 | Flash access error request |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| sys_rst_o | output | 1 | System reset pulse |
| vmon_en_o | output | 1 | Supply monitor enabled as reset source |
| mcd_en_o | output | 1 | Missing-clock detector enabled |
| cmp_en_o | output | 1 | Comparator enabled as reset source |

## Verification
A corrupted cause flag becomes visible at the first register read after the pulse ends. The read data appears one cycle after the strobe and shows a wrong or multiple-hot pattern. An enable register that is lost or wrongly cleared shows at once on the enable output. Its second effect, a reset that fires or fails to fire on a gated request, appears on `sys_rst_o` one cycle after that request. A miscounted pulse length shows as `sys_rst_o` falling early or late, measured edge by edge from the request cycle.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  localparam int NUM_SRC = 7;
  localparam int REG_W   = 8;

  // Index order is the capture priority (lower index wins)
  localparam int SRC_VMON  = 0;
  localparam int SRC_PIN   = 1;
  localparam int SRC_WDT   = 2;
  localparam int SRC_MCD   = 3;
  localparam int SRC_CMP   = 4;
  localparam int SRC_FLASH = 5;
  localparam int SRC_SW    = 6;

  // Register bit positions shared by read and write views
  localparam int BIT_PIN   = 0;
  localparam int BIT_VMON  = 1;
  localparam int BIT_MCD   = 2;
  localparam int BIT_WDT   = 3;
  localparam int BIT_SW    = 4;
  localparam int BIT_CMP   = 5;
  localparam int BIT_FLASH = 6;
  localparam int BIT_FIXED = 7;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  function automatic logic [REG_W-1:0] flags_to_reg(src_vec_t f);
    logic [REG_W-1:0] r;
    r            = '0;
    r[BIT_FIXED] = 1'b1;
    r[BIT_FLASH] = f[SRC_FLASH];
    r[BIT_CMP]   = f[SRC_CMP];
    r[BIT_SW]    = f[SRC_SW];
    r[BIT_WDT]   = f[SRC_WDT];
    r[BIT_MCD]   = f[SRC_MCD];
    r[BIT_VMON]  = f[SRC_VMON];
    r[BIT_PIN]   = f[SRC_PIN];
    return r;
  endfunction

endpackage

// File: rtl/rstcause_arbiter.sv
module rstcause_arbiter #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic taken;

  always_comb begin
    grant_o = '0;
    taken   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        grant_o[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rstcause_pulse.sv
module rstcause_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end
  end
endmodule

// File: rtl/rstcause_regs.sv
module rstcause_regs
  import rstcause_pkg::*;
(
  input  logic             clk,
  input  logic             rst_i,
  input  logic             start_i,
  input  src_vec_t         grant_i,
  input  logic             wr_en_i,
  input  logic             wr_vmon_en_i,
  input  logic             wr_mcd_en_i,
  input  logic             wr_cmp_en_i,
  input  logic             rd_i,
  output src_vec_t         flags_o,
  output logic             vmon_en_o,
  output logic             mcd_en_o,
  output logic             cmp_en_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam src_vec_t POR_FLAGS = src_vec_t'(1) << SRC_VMON;

  logic supply_reset;
  assign supply_reset = start_i && grant_i[SRC_VMON];

  always_ff @(posedge clk) begin
    if (rst_i) begin
      flags_o <= POR_FLAGS;
    end else if (start_i) begin
      flags_o <= grant_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i || supply_reset) begin
      vmon_en_o <= 1'b1;
      mcd_en_o  <= 1'b0;
      cmp_en_o  <= 1'b0;
    end else if (wr_en_i) begin
      vmon_en_o <= wr_vmon_en_i;
      mcd_en_o  <= wr_mcd_en_i;
      cmp_en_o  <= wr_cmp_en_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i)     rdata_o <= '0;
    else if (rd_i) rdata_o <= flags_to_reg(flags_o);
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
#(
  parameter int               PULSE_CYCLES = 16,
  parameter int               ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = ADDR_W'(8'hEF)
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              vmon_req_i,
  input  logic              pin_req_i,
  input  logic              wdt_req_i,
  input  logic              mcd_req_i,
  input  logic              cmp_trip_n_i,
  input  logic              flash_err_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              sys_rst_o,
  output logic              vmon_en_o,
  output logic              mcd_en_o,
  output logic              cmp_en_o
);
  logic     wr_hit, rd_hit, accept, req_any, start;
  src_vec_t req_vec, grant;
  src_vec_t flags_q;
  logic     busy;
  logic     unused_wdata;

  assign wr_hit = bus_wr_i && (bus_addr_i == REG_ADDR);
  assign rd_hit = bus_rd_i && (bus_addr_i == REG_ADDR);
  assign accept = !rst_i && !busy;

  always_comb begin
    req_vec            = '0;
    req_vec[SRC_VMON]  = vmon_req_i && vmon_en_o;
    req_vec[SRC_PIN]   = pin_req_i;
    req_vec[SRC_WDT]   = wdt_req_i;
    req_vec[SRC_MCD]   = mcd_req_i && mcd_en_o;
    req_vec[SRC_CMP]   = !cmp_trip_n_i && cmp_en_o;
    req_vec[SRC_FLASH] = flash_err_i;
    req_vec[SRC_SW]    = wr_hit && bus_wdata_i[BIT_SW];
  end

  rstcause_arbiter #(.N(NUM_SRC)) u_arb (
    .req_i   (req_vec),
    .grant_o (grant),
    .any_o   (req_any)
  );

  assign start = accept && req_any;

  rstcause_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_i   (rst_i),
    .start_i (start),
    .busy_o  (busy)
  );

  rstcause_regs u_regs (
    .clk          (clk),
    .rst_i        (rst_i),
    .start_i      (start),
    .grant_i      (grant),
    .wr_en_i      (wr_hit && accept),
    .wr_vmon_en_i (bus_wdata_i[BIT_VMON]),
    .wr_mcd_en_i  (bus_wdata_i[BIT_MCD]),
    .wr_cmp_en_i  (bus_wdata_i[BIT_CMP]),
    .rd_i         (rd_hit),
    .flags_o      (flags_q),
    .vmon_en_o    (vmon_en_o),
    .mcd_en_o     (mcd_en_o),
    .cmp_en_o     (cmp_en_o),
    .rdata_o      (bus_rdata_o)
  );

  assign sys_rst_o    = busy;
  assign unused_wdata = ^{bus_wdata_i[BIT_FIXED], bus_wdata_i[BIT_FLASH],
                          bus_wdata_i[BIT_WDT], bus_wdata_i[BIT_PIN]};
endmodule

// File: rtl/rstcause_checker.sv
module rstcause_checker
  import rstcause_pkg::*;
#(
  parameter int               PULSE_CYCLES = 16,
  parameter int               ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = ADDR_W'(8'hEF)
) (
  input logic              clk,
  input logic              rst_i,
  input logic              vmon_req_i,
  input logic              pin_req_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [REG_W-1:0]  bus_rdata_o,
  input logic              sys_rst_o,
  input logic              vmon_en_o,
  input logic              mcd_en_o,
  input logic              cmp_en_o,
  input src_vec_t          flags_q
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst_i || !sys_rst_o) run_cnt <= '0;
    else                     run_cnt <= run_cnt + 1'b1;
  end

  // R1
  p_por_enables_r1: assert property (@(posedge clk)
    rst_i |=> (vmon_en_o && !mcd_en_o && !cmp_en_o && sys_rst_o));

  // R2
  p_fixed_bit_r2: assert property (@(posedge clk) disable iff (rst_i)
    (bus_rd_i && bus_addr_i == REG_ADDR) |=> bus_rdata_o[7]);

  // R3
  p_pin_starts_r3: assert property (@(posedge clk) disable iff (rst_i)
    (pin_req_i && !sys_rst_o) |=> sys_rst_o);

  // R3
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst_i)
    run_cnt <= RUN_W'(PULSE_CYCLES));

  // R9
  p_one_cause_r9: assert property (@(posedge clk) disable iff (rst_i)
    $onehot0(flags_q) && (flags_q != '0));

  // R10
  p_enables_hold_r10: assert property (@(posedge clk) disable iff (rst_i)
    (!(bus_wr_i && bus_addr_i == REG_ADDR) && !(vmon_req_i && vmon_en_o))
      |=> $stable({vmon_en_o, mcd_en_o, cmp_en_o}));

  // R11
  p_flags_frozen_r11: assert property (@(posedge clk) disable iff (rst_i)
    sys_rst_o |=> $stable(flags_q));

  // R12
  p_idle_read_r12: assert property (@(posedge clk) disable iff (rst_i)
    !(bus_rd_i && bus_addr_i == REG_ADDR) |=> (bus_rdata_o == '0));
endmodule

bind rstcause_ctrl rstcause_checker #(
  .PULSE_CYCLES (PULSE_CYCLES),
  .ADDR_W       (ADDR_W),
  .REG_ADDR     (REG_ADDR)
) u_chk (
  .clk         (clk),
  .rst_i       (rst_i),
  .vmon_req_i  (vmon_req_i),
  .pin_req_i   (pin_req_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .sys_rst_o   (sys_rst_o),
  .vmon_en_o   (vmon_en_o),
  .mcd_en_o    (mcd_en_o),
  .cmp_en_o    (cmp_en_o),
  .flags_q     (flags_q)
);

// File: tb/rstcause_ctrl_bench.sv
`timescale 1ns/1ps
module rstcause_ctrl_bench;
  localparam int PULSE = 16;
  localparam logic [7:0] RA = 8'hEF;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic vmon_req_i = 0, pin_req_i = 0, wdt_req_i = 0, mcd_req_i = 0;
  logic cmp_trip_n_i = 1, flash_err_i = 0;
  logic [7:0] bus_addr_i = 0;
  logic bus_wr_i = 0, bus_rd_i = 0;
  logic [7:0] bus_wdata_i = 0;
  logic [7:0] bus_rdata_o;
  logic sys_rst_o, vmon_en_o, mcd_en_o, cmp_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rstcause_ctrl #(.PULSE_CYCLES(PULSE)) u_rstcause_ctrl (
    .clk(clk), .rst_i(rst_i), .vmon_req_i(vmon_req_i), .pin_req_i(pin_req_i),
    .wdt_req_i(wdt_req_i), .mcd_req_i(mcd_req_i), .cmp_trip_n_i(cmp_trip_n_i),
    .flash_err_i(flash_err_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .sys_rst_o(sys_rst_o), .vmon_en_o(vmon_en_o), .mcd_en_o(mcd_en_o),
    .cmp_en_o(cmp_en_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(string tag, logic [7:0] addr, logic [7:0] exp);
    bus_addr_i = addr; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    check(tag, bus_rdata_o, exp);
  endtask

  task automatic do_write(logic [7:0] data);
    bus_addr_i = RA; bus_wdata_i = data; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = 8'h00;
  endtask

  // Counts negedges with sys_rst_o high, starting at the current one
  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_reqs();
    vmon_req_i = 0; pin_req_i = 0; wdt_req_i = 0; mcd_req_i = 0;
    cmp_trip_n_i = 1; flash_err_i = 0;
  endtask

  task automatic expect_no_pulse(string tag);
    @(negedge clk);
    clear_reqs();
    check(tag, sys_rst_o, 0);
    @(negedge clk);
    check(tag, sys_rst_o, 0);
  endtask

  task automatic expect_pulse(string tag);
    int n;
    @(negedge clk);
    clear_reqs();
    pulse_len(n);
    check(tag, n, PULSE);
  endtask

  task automatic t_por();
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    begin
      int n;
      pulse_len(n);
      check("R1 power-on pulse length", n, PULSE);
    end
    check("R1 vmon_en after power-on", vmon_en_o, 1);
    check("R1 mcd_en after power-on", mcd_en_o, 0);
    check("R1 cmp_en after power-on", cmp_en_o, 0);
    do_read("R1 R2 power-on readback", RA, 8'h82);
  endtask

  task automatic t_read_port();
    do_read("R12 other address reads zero", 8'hEE, 8'h00);
    @(negedge clk);
    check("R12 idle read data zero", bus_rdata_o, 0);
  endtask

  task automatic t_simple_causes();
    pin_req_i = 1; expect_pulse("R3 pin pulse length");
    do_read("R4 pin flag", RA, 8'h81);
    wdt_req_i = 1; expect_pulse("R3 watchdog pulse length");
    do_read("R4 watchdog flag", RA, 8'h88);
    flash_err_i = 1; expect_pulse("R3 flash pulse length");
    do_read("R4 flash flag", RA, 8'hC0);
  endtask

  task automatic t_software();
    do_write(8'h82);
    check("R5 write bit4=0 no reset", sys_rst_o, 0);
    @(negedge clk);
    check("R5 write bit4=0 no reset later", sys_rst_o, 0);
    do_read("R2 bit7 write ignored", RA, 8'hC0);
    bus_addr_i = RA; bus_wdata_i = 8'h12; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
    begin
      int n;
      pulse_len(n);
      check("R5 software pulse length", n, PULSE);
    end
    do_read("R5 software flag", RA, 8'h90);
    check("R10 vmon_en kept after software reset", vmon_en_o, 1);
  endtask

  task automatic t_missing_clock();
    mcd_req_i = 1; expect_no_pulse("R6 missing clock gated off");
    do_write(8'h06);
    check("R6 mcd_en set by write", mcd_en_o, 1);
    mcd_req_i = 1; expect_pulse("R6 missing clock pulse");
    do_read("R6 missing clock flag", RA, 8'h84);
    check("R10 mcd_en kept after reset", mcd_en_o, 1);
  endtask

  task automatic t_comparator();
    cmp_trip_n_i = 0; expect_no_pulse("R7 comparator gated off");
    do_write(8'h26);
    check("R7 cmp_en set by write", cmp_en_o, 1);
    cmp_trip_n_i = 0; expect_pulse("R7 comparator pulse");
    do_read("R7 comparator flag", RA, 8'hA0);
    check("R10 cmp_en kept", cmp_en_o, 1);
    check("R10 mcd_en kept", mcd_en_o, 1);
  endtask

  task automatic t_priority();
    pin_req_i = 1; wdt_req_i = 1; flash_err_i = 1;
    expect_pulse("R9 pin+wdt+flash pulse");
    do_read("R9 pin wins", RA, 8'h81);
    wdt_req_i = 1; mcd_req_i = 1; cmp_trip_n_i = 0;
    expect_pulse("R9 wdt+mcd+cmp pulse");
    do_read("R9 watchdog wins", RA, 8'h88);
    mcd_req_i = 1; cmp_trip_n_i = 0;
    expect_pulse("R9 mcd+cmp pulse");
    do_read("R9 missing clock wins", RA, 8'h84);
    vmon_req_i = 1; pin_req_i = 1;
    expect_pulse("R8 supply pulse");
    do_read("R8 R9 supply wins", RA, 8'h82);
    check("R8 vmon_en default", vmon_en_o, 1);
    check("R8 mcd_en default", mcd_en_o, 0);
    check("R8 cmp_en default", cmp_en_o, 0);
  endtask

  task automatic t_vmon_disabled();
    do_write(8'h00);
    check("R8 vmon_en cleared", vmon_en_o, 0);
    vmon_req_i = 1; expect_no_pulse("R8 supply gated off");
    do_write(8'h02);
    check("R8 vmon_en restored", vmon_en_o, 1);
  endtask

  task automatic t_busy_ignore();
    int n;
    pin_req_i = 1;
    @(negedge clk);
    pin_req_i = 0;
    n = 0;
    repeat (2) begin
      if (sys_rst_o) n++;
      @(negedge clk);
    end
    wdt_req_i = 1;
    bus_addr_i = RA; bus_wdata_i = 8'h26; bus_wr_i = 1'b1;
    if (sys_rst_o) n++;
    @(negedge clk);
    wdt_req_i = 0; bus_wr_i = 1'b0; bus_wdata_i = 8'h00;
    while (sys_rst_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R11 R3 no retrigger during pulse", n, PULSE);
    do_read("R11 flag unchanged by busy request", RA, 8'h81);
    check("R11 write ignored during pulse mcd_en", mcd_en_o, 0);
    check("R11 write ignored during pulse cmp_en", cmp_en_o, 0);
  endtask

  initial begin
    @(negedge clk);
    check("R1 pulse during power-on", sys_rst_o, 1);
    t_por();
    t_read_port();
    t_simple_causes();
    t_software();
    t_missing_clock();
    t_comparator();
    t_priority();
    t_vmon_disabled();
    t_busy_ignore();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule